// File: doc/BRIEF.md
# Transactional Access Signature and Conflict Recorder

This block sits beside one core's private cache and records which other cores a running transaction conflicts with, and in which way. Two Bloom-filter signatures hold a compact, over-approximated summary of the line addresses the transaction has touched. The read signature takes transactional loads and the write signature takes transactional stores. Each coherence request that arrives from another core is tested against both signatures. The outcome is returned in a registered response, so that the requester can see the conflict too.

Three per-core bitmaps record conflicts but do not resolve them:
- **read-vs-write:** a local read met a remote write.
- **write-vs-write:** a local write met a remote write.
- **write-vs-read:** a local write met a remote read.

A bitmap bit is set from two sources. One is this core's own signature hits on incoming requests. The other is the conflict flags carried back in responses to this core's own requests. Software reads the bitmaps as whole vectors and decides when and whom to abort. A one-cycle strobe marks each cycle in which some bitmap bit newly became 1.

Software drives the signatures through a small command port:
- Insert an address into either signature.
- Test an address for membership.
- Peek at a single signature bit.
- Arm local capture.
- Clear everything. This is done on commit or abort and takes one cycle.

Top module: `txsig_conflict_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after, all bitmaps, `conf_evt`, `rsp_valid`, `rsp_core`, both hit flags, `cmd_rvalid` and `cmd_rdata` are 0, both signatures are empty, and local capture is disarmed.
- R2: Hash k (k = 0, 1, 2) of line address A is the XOR of the 11-bit chunks of A rotated left by 7*k bits, with the top chunk zero-padded. An insert sets the three hashed bits, and a membership test returns 1 exactly when all three are set. Any inserted address therefore tests as a member.
- R3: Local capture is controlled by arming.
  - When armed, a local access (`loc_valid`) inserts `loc_addr` into the write signature if `loc_is_store` is 1, and into the read signature otherwise.
  - When disarmed, local accesses change no signature.
  - An arm command takes effect for accesses in the following cycle.
- R4: One cycle after a request with `req_valid`, `rsp_valid` is 1 and `rsp_core` equals `req_core`. `rsp_rd_hit` and `rsp_wr_hit` give the membership of `req_addr` in the read and write signatures as they stood before that edge. With no request, all four outputs are 0.
- R5: An incoming request from core i sets bitmap bits as follows, and bits stay set until a clear:
  - A write request that hits the read signature sets read-vs-write bit i.
  - A write request that hits the write signature sets write-vs-write bit i.
  - A read request that hits the write signature sets write-vs-read bit i.
  - A read request that hits only the read signature sets nothing.
- R6: A response received for this core's own request, from core j, sets bits only while armed:
  - Own write with the responder's read flag sets write-vs-read bit j.
  - Own write with the responder's write flag sets write-vs-write bit j.
  - Own read with the responder's write flag sets read-vs-write bit j.
  - Own read with only the read flag sets nothing.
- R7: `conf_evt` is 1 for exactly the cycles in which at least one bitmap bit has just gone from 0 to 1. Setting bits that are already 1 raises no strobe.
- R8: Command op 4 (clear) empties both signatures, zeroes all bitmaps and `conf_evt`, and disarms, all in one cycle. It takes priority over any insert, set or arm in the same cycle.
- R9: Command op 2 (peek) returns, one cycle later on `cmd_rdata`, the signature bit at index `cmd_arg[10:0]`. `cmd_sel_wr` selects the signature: 0 for read, 1 for write.
- R10: Command op 1 (test) returns the membership of `cmd_arg` in the selected signature one cycle later. `cmd_rvalid` is 1 in exactly the cycle after a test or peek and is 0 otherwise. In that case `cmd_rdata` is 0.
- R11: Command op 0 (insert) adds `cmd_arg` to the selected signature whether or not capture is armed. Op 3 arms capture. Ops 5 to 7 have no effect.
- R12: A local access, a software insert, an incoming request and a received response in the same cycle all take effect together, and their bitmap sets are ORed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_valid | input | 1 | Local transactional access this cycle |
| loc_is_store | input | 1 | 1 = transactional store, 0 = transactional load |
| loc_addr | input | ADDR_W | Line address of the local access |
| req_valid | input | 1 | Incoming coherence request from another core |
| req_core | input | CORE_W | Requesting core ID |
| req_is_write | input | 1 | 1 = exclusive/write request, 0 = read request |
| req_addr | input | ADDR_W | Line address of the incoming request |
| own_valid | input | 1 | Response received for this core's own request |
| own_core | input | CORE_W | Responding core ID |
| own_is_write | input | 1 | This core's request was a write |
| own_rd_flag | input | 1 | Responder's read signature hit |
| own_wr_flag | input | 1 | Responder's write signature hit |
| cmd_valid | input | 1 | Software command strobe |
| cmd_op | input | 3 | 0 insert, 1 test, 2 peek, 3 arm, 4 clear |
| cmd_sel_wr | input | 1 | 0 = read signature, 1 = write signature |
| cmd_arg | input | ADDR_W | Address for insert/test; bit index for peek |
| rsp_valid | output | 1 | Response to an incoming request |
| rsp_core | output | CORE_W | Core the response is for |
| rsp_rd_hit | output | 1 | Request address hit the read signature |
| rsp_wr_hit | output | 1 | Request address hit the write signature |
| cmd_rvalid | output | 1 | Test or peek result valid |
| cmd_rdata | output | 1 | Test or peek result |
| tbl_rw | output | NCORES | Read-vs-remote-write bitmap |
| tbl_ww | output | NCORES | Write-vs-remote-write bitmap |
| tbl_wr | output | NCORES | Write-vs-remote-read bitmap |
| conf_evt | output | 1 | New conflict bit recorded this cycle |

## Verification
The assertions take for granted that `NCORES` and `SIG_BITS` are powers of two, so every core ID and every hash index is in range. They also assume reset is held for at least one clock before any traffic, and that `cmd_op` carries a known value whenever `cmd_valid` is high. The bench keeps within these rules. It holds reset for several cycles with every strobe low, and draws core IDs from 0 to 15 and ops from the defined set, apart from the rare clear. Addresses come from a small pool, so hits, repeats and false positives all occur naturally.

// File: rtl/txsig_pkg.sv
package txsig_pkg;
  typedef enum logic [2:0] {
    SCMD_INSERT = 3'd0,
    SCMD_TEST   = 3'd1,
    SCMD_PEEK   = 3'd2,
    SCMD_ARM    = 3'd3,
    SCMD_CLEAR  = 3'd4
  } sig_cmd_e;
endpackage

// File: rtl/sig_hash.sv
module sig_hash #(
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 11,
  parameter int NHASH    = 3,
  parameter int ROT_STEP = 7
) (
  input  logic [ADDR_W-1:0]            addr,
  output logic [NHASH-1:0][IDX_W-1:0]  idx
);
  localparam int NCHUNK = (ADDR_W + IDX_W - 1) / IDX_W;
  localparam int PADW   = NCHUNK * IDX_W;

  for (genvar k = 0; k < NHASH; k++) begin : g_fn
    localparam int SH = (ROT_STEP * k) % ADDR_W;
    logic [ADDR_W-1:0] rot;
    logic [PADW-1:0]   pad;
    logic [IDX_W-1:0]  fold;

    if (SH == 0) begin : g_plain
      assign rot = addr;
    end else begin : g_rot
      assign rot = {addr[ADDR_W-SH-1:0], addr[ADDR_W-1:ADDR_W-SH]};
    end

    assign pad = PADW'(rot);

    always_comb begin
      fold = '0;
      for (int c = 0; c < NCHUNK; c++) fold = fold ^ pad[c*IDX_W +: IDX_W];
    end

    assign idx[k] = fold;
  end
endmodule

// File: rtl/sig_store.sv
module sig_store #(
  parameter int ADDR_W   = 32,
  parameter int SIG_BITS = 2048,
  parameter int NHASH    = 3,
  parameter int ROT_STEP = 7,
  localparam int IDX_W   = $clog2(SIG_BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              ins0_en,
  input  logic [ADDR_W-1:0] ins0_addr,
  input  logic              ins1_en,
  input  logic [ADDR_W-1:0] ins1_addr,
  input  logic [ADDR_W-1:0] qa_addr,
  output logic              qa_hit,
  input  logic [ADDR_W-1:0] qb_addr,
  output logic              qb_hit,
  input  logic [IDX_W-1:0]  peek_idx,
  output logic              peek_bit
);
  localparam int NPORT = 4;  // 0 ins0, 1 ins1, 2 query a, 3 query b

  logic [SIG_BITS-1:0]               bits;
  logic [NPORT-1:0][ADDR_W-1:0]      port_addr;
  logic [NHASH-1:0][IDX_W-1:0]       port_idx [NPORT];

  assign port_addr = {qb_addr, qa_addr, ins1_addr, ins0_addr};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    sig_hash #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .NHASH(NHASH), .ROT_STEP(ROT_STEP)
    ) u_hash (
      .addr(port_addr[p]),
      .idx (port_idx[p])
    );
  end

  // Single-cycle clear forces a flop array rather than block RAM.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      bits <= '0;
    end else begin
      for (int k = 0; k < NHASH; k++) begin
        if (ins0_en) bits[port_idx[0][k]] <= 1'b1;
        if (ins1_en) bits[port_idx[1][k]] <= 1'b1;
      end
    end
  end

  always_comb begin
    qa_hit = 1'b1;
    qb_hit = 1'b1;
    for (int k = 0; k < NHASH; k++) begin
      qa_hit = qa_hit & bits[port_idx[2][k]];
      qb_hit = qb_hit & bits[port_idx[3][k]];
    end
  end

  assign peek_bit = bits[peek_idx];

  for (genvar k = 0; k < NHASH; k++) begin : g_chk
    p_insert_sets_bit_r2: assert property (@(posedge clk) disable iff (rst)
      (ins0_en && !clr) |=> bits[$past(port_idx[0][k])]);
    p_swins_sets_bit_r2: assert property (@(posedge clk) disable iff (rst)
      (ins1_en && !clr) |=> bits[$past(port_idx[1][k])]);
  end

  p_clear_empties_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (bits == '0));
endmodule

// File: rtl/sig_conf_tables.sv
module sig_conf_tables #(
  parameter int NCORES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [NCORES-1:0] set_rw,
  input  logic [NCORES-1:0] set_ww,
  input  logic [NCORES-1:0] set_wr,
  output logic [NCORES-1:0] rw,
  output logic [NCORES-1:0] ww,
  output logic [NCORES-1:0] wr,
  output logic              evt
);
  logic [NCORES-1:0] fresh;

  assign fresh = (set_rw & ~rw) | (set_ww & ~ww) | (set_wr & ~wr);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rw  <= '0;
      ww  <= '0;
      wr  <= '0;
      evt <= 1'b0;
    end else begin
      rw  <= rw | set_rw;
      ww  <= ww | set_ww;
      wr  <= wr | set_wr;
      evt <= |fresh;
    end
  end

  p_evt_marks_new_bit_r7: assert property (@(posedge clk) disable iff (rst)
    evt |-> ((rw != $past(rw)) || (ww != $past(ww)) || (wr != $past(wr))));

  p_tables_cleared_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (rw == '0 && ww == '0 && wr == '0 && !evt));

  p_bits_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((($past(rw) & ~rw) == '0) && (($past(ww) & ~ww) == '0) &&
              (($past(wr) & ~wr) == '0)));
endmodule

// File: rtl/txsig_conflict_unit.sv
module txsig_conflict_unit
  import txsig_pkg::*;
#(
  parameter int NCORES   = 16,
  parameter int ADDR_W   = 32,
  parameter int SIG_BITS = 2048,
  parameter int NHASH    = 3,
  parameter int ROT_STEP = 7,
  localparam int CORE_W  = $clog2(NCORES),
  localparam int IDX_W   = $clog2(SIG_BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loc_valid,
  input  logic              loc_is_store,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic              req_valid,
  input  logic [CORE_W-1:0] req_core,
  input  logic              req_is_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              own_valid,
  input  logic [CORE_W-1:0] own_core,
  input  logic              own_is_write,
  input  logic              own_rd_flag,
  input  logic              own_wr_flag,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic              cmd_sel_wr,
  input  logic [ADDR_W-1:0] cmd_arg,
  output logic              rsp_valid,
  output logic [CORE_W-1:0] rsp_core,
  output logic              rsp_rd_hit,
  output logic              rsp_wr_hit,
  output logic              cmd_rvalid,
  output logic              cmd_rdata,
  output logic [NCORES-1:0] tbl_rw,
  output logic [NCORES-1:0] tbl_ww,
  output logic [NCORES-1:0] tbl_wr,
  output logic              conf_evt
);
  sig_cmd_e op;
  logic do_ins, do_test, do_peek, do_arm, do_clr;
  logic armed;

  assign op      = sig_cmd_e'(cmd_op);
  assign do_ins  = cmd_valid && (op == SCMD_INSERT);
  assign do_test = cmd_valid && (op == SCMD_TEST);
  assign do_peek = cmd_valid && (op == SCMD_PEEK);
  assign do_arm  = cmd_valid && (op == SCMD_ARM);
  assign do_clr  = cmd_valid && (op == SCMD_CLEAR);

  // ---------------- signatures ----------------
  logic rd_qa_hit, rd_qb_hit, rd_peek;
  logic wr_qa_hit, wr_qb_hit, wr_peek;
  logic loc_ld, loc_st;

  assign loc_ld = armed && loc_valid && !loc_is_store;
  assign loc_st = armed && loc_valid &&  loc_is_store;

  sig_store #(
    .ADDR_W(ADDR_W), .SIG_BITS(SIG_BITS), .NHASH(NHASH), .ROT_STEP(ROT_STEP)
  ) u_rd_sig (
    .clk(clk), .rst(rst), .clr(do_clr),
    .ins0_en(loc_ld), .ins0_addr(loc_addr),
    .ins1_en(do_ins && !cmd_sel_wr), .ins1_addr(cmd_arg),
    .qa_addr(req_addr), .qa_hit(rd_qa_hit),
    .qb_addr(cmd_arg),  .qb_hit(rd_qb_hit),
    .peek_idx(cmd_arg[IDX_W-1:0]), .peek_bit(rd_peek)
  );

  sig_store #(
    .ADDR_W(ADDR_W), .SIG_BITS(SIG_BITS), .NHASH(NHASH), .ROT_STEP(ROT_STEP)
  ) u_wr_sig (
    .clk(clk), .rst(rst), .clr(do_clr),
    .ins0_en(loc_st), .ins0_addr(loc_addr),
    .ins1_en(do_ins && cmd_sel_wr), .ins1_addr(cmd_arg),
    .qa_addr(req_addr), .qa_hit(wr_qa_hit),
    .qb_addr(cmd_arg),  .qb_hit(wr_qb_hit),
    .peek_idx(cmd_arg[IDX_W-1:0]), .peek_bit(wr_peek)
  );

  // ---------------- conflict classification ----------------
  logic [NCORES-1:0] req_hot, own_hot;
  logic [NCORES-1:0] set_rw, set_ww, set_wr;

  for (genvar i = 0; i < NCORES; i++) begin : g_dec
    assign req_hot[i] = req_valid && (req_core == CORE_W'(i));
    assign own_hot[i] = own_valid && armed && (own_core == CORE_W'(i));
  end

  always_comb begin
    set_rw = (req_hot & {NCORES{ req_is_write && rd_qa_hit}})
           | (own_hot & {NCORES{!own_is_write && own_wr_flag}});
    set_ww = (req_hot & {NCORES{ req_is_write && wr_qa_hit}})
           | (own_hot & {NCORES{ own_is_write && own_wr_flag}});
    set_wr = (req_hot & {NCORES{!req_is_write && wr_qa_hit}})
           | (own_hot & {NCORES{ own_is_write && own_rd_flag}});
  end

  sig_conf_tables #(.NCORES(NCORES)) u_tables (
    .clk(clk), .rst(rst), .clr(do_clr),
    .set_rw(set_rw), .set_ww(set_ww), .set_wr(set_wr),
    .rw(tbl_rw), .ww(tbl_ww), .wr(tbl_wr), .evt(conf_evt)
  );

  // ---------------- registered responses ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_core   <= '0;
      rsp_rd_hit <= 1'b0;
      rsp_wr_hit <= 1'b0;
      cmd_rvalid <= 1'b0;
      cmd_rdata  <= 1'b0;
      armed      <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_core   <= req_valid ? req_core : '0;
      rsp_rd_hit <= req_valid && rd_qa_hit;
      rsp_wr_hit <= req_valid && wr_qa_hit;
      cmd_rvalid <= do_test || do_peek;
      if (do_test)      cmd_rdata <= cmd_sel_wr ? wr_qb_hit : rd_qb_hit;
      else if (do_peek) cmd_rdata <= cmd_sel_wr ? wr_peek : rd_peek;
      else              cmd_rdata <= 1'b0;
      if (do_clr)       armed <= 1'b0;
      else if (do_arm)  armed <= 1'b1;
    end
  end

  p_rsp_follows_req_r4: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_valid && rsp_core == $past(req_core)));

  p_rsp_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_rd_hit && !rsp_wr_hit));

  p_result_after_query_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_rvalid |-> $past(cmd_valid));

  p_clear_disarms_r8: assert property (@(posedge clk) disable iff (rst)
    do_clr |=> !armed);
endmodule

// File: tb/txsig_conflict_unit_test.sv
`timescale 1ns/1ps
module txsig_conflict_unit_test;
  localparam int NC = 16;
  localparam int AW = 32;
  localparam int SB = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          loc_valid, loc_is_store;
  logic [AW-1:0] loc_addr;
  logic          req_valid, req_is_write;
  logic [3:0]    req_core;
  logic [AW-1:0] req_addr;
  logic          own_valid, own_is_write, own_rd_flag, own_wr_flag;
  logic [3:0]    own_core;
  logic          cmd_valid, cmd_sel_wr;
  logic [2:0]    cmd_op;
  logic [AW-1:0] cmd_arg;
  logic          rsp_valid, rsp_rd_hit, rsp_wr_hit, cmd_rvalid, cmd_rdata, conf_evt;
  logic [3:0]    rsp_core;
  logic [NC-1:0] tbl_rw, tbl_ww, tbl_wr;

  txsig_conflict_unit uut (
    .clk(clk), .rst(rst),
    .loc_valid(loc_valid), .loc_is_store(loc_is_store), .loc_addr(loc_addr),
    .req_valid(req_valid), .req_core(req_core), .req_is_write(req_is_write),
    .req_addr(req_addr),
    .own_valid(own_valid), .own_core(own_core), .own_is_write(own_is_write),
    .own_rd_flag(own_rd_flag), .own_wr_flag(own_wr_flag),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sel_wr(cmd_sel_wr), .cmd_arg(cmd_arg),
    .rsp_valid(rsp_valid), .rsp_core(rsp_core), .rsp_rd_hit(rsp_rd_hit),
    .rsp_wr_hit(rsp_wr_hit), .cmd_rvalid(cmd_rvalid), .cmd_rdata(cmd_rdata),
    .tbl_rw(tbl_rw), .tbl_ww(tbl_ww), .tbl_wr(tbl_wr), .conf_evt(conf_evt)
  );

  int errors = 0;
  int checks = 0;
  string phase = "R1 reset";

  // ---------------- reference model ----------------
  bit         m_sig [2][SB];
  bit         m_armed;
  logic [NC-1:0] e_rw, e_ww, e_wr;
  logic       e_evt, e_rsp_valid, e_rsp_rd, e_rsp_wr, e_rvalid, e_rdata;
  logic [3:0] e_rsp_core;

  function automatic int bhash(input logic [AW-1:0] a, input int k);
    logic [AW-1:0] r;
    int s, idx;
    s = (7 * k) % AW;
    r = (s == 0) ? a : ((a << s) | (a >> (AW - s)));
    idx = 0;
    for (int b = 0; b < AW; b++) if (r[b]) idx = idx ^ (1 << (b % 11));
    return idx;
  endfunction

  function automatic bit member(input int sel, input logic [AW-1:0] a);
    bit h;
    h = 1'b1;
    for (int k = 0; k < 3; k++) h = h & m_sig[sel][bhash(a, k)];
    return h;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < 2; s++) for (int i = 0; i < SB; i++) m_sig[s][i] = 1'b0;
    m_armed = 1'b0;
    e_rw = '0; e_ww = '0; e_wr = '0; e_evt = 1'b0;
    e_rsp_valid = 1'b0; e_rsp_core = '0; e_rsp_rd = 1'b0; e_rsp_wr = 1'b0;
    e_rvalid = 1'b0; e_rdata = 1'b0;
  endtask

  task automatic model_step();
    bit q_rd, q_wr, clr;
    logic [NC-1:0] srw, sww, swr;
    int sel;
    q_rd = member(0, req_addr);
    q_wr = member(1, req_addr);
    sel  = cmd_sel_wr ? 1 : 0;
    clr  = cmd_valid && (cmd_op == 3'd4);
    e_rsp_valid = req_valid;
    e_rsp_core  = req_valid ? req_core : 4'd0;
    e_rsp_rd    = req_valid && q_rd;
    e_rsp_wr    = req_valid && q_wr;
    e_rvalid = cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd2);
    e_rdata  = 1'b0;
    if (cmd_valid && cmd_op == 3'd1) e_rdata = member(sel, cmd_arg);
    if (cmd_valid && cmd_op == 3'd2) e_rdata = m_sig[sel][int'(cmd_arg[10:0])];
    srw = '0; sww = '0; swr = '0;
    if (req_valid) begin
      if (req_is_write && q_rd)  srw[req_core] = 1'b1;
      if (req_is_write && q_wr)  sww[req_core] = 1'b1;
      if (!req_is_write && q_wr) swr[req_core] = 1'b1;
    end
    if (own_valid && m_armed) begin
      if (own_is_write && own_rd_flag)  swr[own_core] = 1'b1;
      if (own_is_write && own_wr_flag)  sww[own_core] = 1'b1;
      if (!own_is_write && own_wr_flag) srw[own_core] = 1'b1;
    end
    if (clr) begin
      for (int s = 0; s < 2; s++) for (int i = 0; i < SB; i++) m_sig[s][i] = 1'b0;
      m_armed = 1'b0;
      e_rw = '0; e_ww = '0; e_wr = '0; e_evt = 1'b0;
    end else begin
      e_evt = |((srw & ~e_rw) | (sww & ~e_ww) | (swr & ~e_wr));
      e_rw = e_rw | srw; e_ww = e_ww | sww; e_wr = e_wr | swr;
      if (m_armed && loc_valid)
        for (int k = 0; k < 3; k++) m_sig[loc_is_store ? 1 : 0][bhash(loc_addr, k)] = 1'b1;
      if (cmd_valid && cmd_op == 3'd0)
        for (int k = 0; k < 3; k++) m_sig[sel][bhash(cmd_arg, k)] = 1'b1;
      if (cmd_valid && cmd_op == 3'd3) m_armed = 1'b1;
    end
  endtask

  // ---------------- checking ----------------
  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", phase, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("rsp_valid",  64'(rsp_valid),  64'(e_rsp_valid));
    check("rsp_core",   64'(rsp_core),   64'(e_rsp_core));
    check("rsp_rd_hit", 64'(rsp_rd_hit), 64'(e_rsp_rd));
    check("rsp_wr_hit", 64'(rsp_wr_hit), 64'(e_rsp_wr));
    check("cmd_rvalid", 64'(cmd_rvalid), 64'(e_rvalid));
    check("cmd_rdata",  64'(cmd_rdata),  64'(e_rdata));
    check("tbl_rw",     64'(tbl_rw),     64'(e_rw));
    check("tbl_ww",     64'(tbl_ww),     64'(e_ww));
    check("tbl_wr",     64'(tbl_wr),     64'(e_wr));
    check("conf_evt",   64'(conf_evt),   64'(e_evt));
  endtask

  task automatic idle();
    loc_valid = 0; loc_is_store = 0; loc_addr = '0;
    req_valid = 0; req_core = '0; req_is_write = 0; req_addr = '0;
    own_valid = 0; own_core = '0; own_is_write = 0; own_rd_flag = 0; own_wr_flag = 0;
    cmd_valid = 0; cmd_op = '0; cmd_sel_wr = 0; cmd_arg = '0;
  endtask

  task automatic cyc();
    model_step();
    @(negedge clk);
    compare_all();
    idle();
  endtask

  task automatic cmd(input logic [2:0] o, input logic s, input logic [AW-1:0] a);
    cmd_valid = 1; cmd_op = o; cmd_sel_wr = s; cmd_arg = a;
    cyc();
  endtask

  task automatic loc(input logic st, input logic [AW-1:0] a);
    loc_valid = 1; loc_is_store = st; loc_addr = a;
    cyc();
  endtask

  task automatic req(input logic [3:0] c, input logic w, input logic [AW-1:0] a);
    req_valid = 1; req_core = c; req_is_write = w; req_addr = a;
    cyc();
  endtask

  task automatic own(input logic [3:0] c, input logic w, input logic rf, input logic wf);
    own_valid = 1; own_core = c; own_is_write = w; own_rd_flag = rf; own_wr_flag = wf;
    cyc();
  endtask

  localparam logic [AW-1:0] A = 32'h0000_1234;
  localparam logic [AW-1:0] B = 32'h0000_5678;
  localparam logic [AW-1:0] C = 32'h00ab_cdef;
  localparam logic [AW-1:0] E = 32'h0031_0c07;

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    idle();
    model_reset();
    repeat (3) @(negedge clk);
    phase = "R1 reset";
    compare_all();
    rst = 0;
    cyc();
    cmd(3'd1, 0, A); check("R1 read sig empty", 64'(cmd_rdata), 64'd0);
    cmd(3'd1, 1, A); check("R1 write sig empty", 64'(cmd_rdata), 64'd0);

    phase = "R3 local capture";
    loc(0, A); loc(1, B);
    cmd(3'd1, 0, A); check("R3 disarmed load ignored", 64'(cmd_rdata), 64'd0);
    cmd(3'd1, 1, B); check("R3 disarmed store ignored", 64'(cmd_rdata), 64'd0);
    cmd(3'd3, 0, '0);
    loc(0, A); loc(1, B);
    cmd(3'd1, 0, A); check("R3 armed load captured", 64'(cmd_rdata), 64'd1);
    cmd(3'd1, 1, B); check("R3 armed store captured", 64'(cmd_rdata), 64'd1);

    phase = "R11 software insert";
    cmd(3'd0, 1, C);
    cmd(3'd1, 1, C); check("R11 inserted write sig", 64'(cmd_rdata), 64'd1);
    cmd(3'd5, 0, E);
    cmd(3'd1, 0, C);

    phase = "R2 membership";
    for (int i = 0; i < 8; i++) cmd(3'd0, 0, 32'h7000 + 32'(i) * 32'd4099);
    for (int i = 0; i < 8; i++) begin
      cmd(3'd1, 0, 32'h7000 + 32'(i) * 32'd4099);
      check("R2 inserted is member", 64'(cmd_rdata), 64'd1);
    end

    phase = "R9 peek";
    for (int k = 0; k < 3; k++) begin
      cmd(3'd2, 0, 32'(bhash(A, k)));
      check("R9 hashed bit set", 64'(cmd_rdata), 64'd1);
    end
    cmd(3'd2, 1, 32'd5); cmd(3'd2, 0, 32'd2047);

    phase = "R10 test timing";
    cmd(3'd1, 0, A);
    check("R10 rvalid after test", 64'(cmd_rvalid), 64'd1);
    cyc();
    check("R10 rvalid drops", 64'(cmd_rvalid), 64'd0);

    phase = "R4 R5 remote";
    req(4'd3, 1, A);
    check("R4 rsp core", 64'(rsp_core), 64'd3);
    check("R4 rd hit", 64'(rsp_rd_hit), 64'd1);
    check("R5 rw bit", 64'(tbl_rw[3]), 64'd1);
    check("R7 first set strobes", 64'(conf_evt), 64'd1);
    phase = "R7 repeat";
    req(4'd3, 1, A);
    check("R7 repeat no strobe", 64'(conf_evt), 64'd0);
    phase = "R4 R5 remote";
    req(4'd5, 0, B); check("R5 wr bit", 64'(tbl_wr[5]), 64'd1);
    req(4'd7, 1, B); check("R5 ww bit", 64'(tbl_ww[7]), 64'd1);
    req(4'd9, 0, A);
    req(4'd1, 0, 32'hdead_0000);

    phase = "R6 own responses";
    own(4'd2, 1, 1, 0); check("R6 own write rd flag", 64'(tbl_wr[2]), 64'd1);
    own(4'd4, 0, 0, 1); check("R6 own read wr flag", 64'(tbl_rw[4]), 64'd1);
    own(4'd6, 1, 0, 1); check("R6 own write wr flag", 64'(tbl_ww[6]), 64'd1);
    own(4'd8, 0, 1, 0);
    check("R6 read-read no set", 64'({tbl_rw[8], tbl_ww[8], tbl_wr[8]}), 64'd0);

    phase = "R12 overlap";
    req_valid = 1; req_core = 4'd10; req_is_write = 1; req_addr = A;
    own_valid = 1; own_core = 4'd11; own_is_write = 1; own_wr_flag = 1;
    loc_valid = 1; loc_is_store = 1; loc_addr = E;
    cyc();
    check("R12 both bits", 64'({tbl_rw[10], tbl_ww[11]}), 64'd3);
    cmd(3'd1, 1, E); check("R12 local store same cycle", 64'(cmd_rdata), 64'd1);

    phase = "R8 clear";
    cmd_valid = 1; cmd_op = 3'd4;
    req_valid = 1; req_core = 4'd12; req_is_write = 1; req_addr = A;
    loc_valid = 1; loc_is_store = 0; loc_addr = C;
    cyc();
    check("R8 tables zero", 64'({tbl_rw, tbl_ww, tbl_wr}), 64'd0);
    check("R8 no strobe", 64'(conf_evt), 64'd0);
    cmd(3'd1, 0, A); check("R8 read sig emptied", 64'(cmd_rdata), 64'd0);
    cmd(3'd1, 0, C); check("R8 clear beats insert", 64'(cmd_rdata), 64'd0);
    own(4'd13, 1, 0, 1); check("R6 disarmed own ignored", 64'(tbl_ww[13]), 64'd0);
    loc(0, A);
    cmd(3'd1, 0, A); check("R8 clear disarms", 64'(cmd_rdata), 64'd0);

    phase = "R12 random mix";
    cmd(3'd3, 0, '0);
    for (int n = 0; n < 4000; n++) begin
      loc_valid = ($urandom % 2) == 0; loc_is_store = $urandom % 2;
      loc_addr = 32'(($urandom % 24) * 32'h9e37);
      req_valid = ($urandom % 2) == 0; req_is_write = $urandom % 2;
      req_core = 4'($urandom % 16);
      req_addr = 32'(($urandom % 24) * 32'h9e37);
      own_valid = ($urandom % 3) == 0; own_is_write = $urandom % 2;
      own_core = 4'($urandom % 16);
      own_rd_flag = $urandom % 2; own_wr_flag = $urandom % 2;
      cmd_valid = ($urandom % 5) == 0; cmd_sel_wr = $urandom % 2;
      cmd_op = ($urandom % 60 == 0) ? 3'd4 : 3'($urandom % 4);
      cmd_arg = ($urandom % 2) ? 32'(($urandom % 24) * 32'h9e37) : 32'($urandom % SB);
      if (n % 700 == 0) begin cmd_valid = 1; cmd_op = 3'd3; end
      cyc();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule